// File: doc/BRIEF.md
# Supply-Fail Reset Sequencer

This block turns a digital "supply is above its trip level" flag, produced by an external comparator, into an active-low system reset. Reset is held from power-up and whenever the flag drops. It is released only after the flag has stayed high for a fixed number of ticks of a slow timebase. The default of 200 ticks at a 1 ms tick gives a hold near the nominal figure and inside the permitted 100 ms to 280 ms window. A low sample of the flag during the hold throws the progress away, and the count starts again from zero.

The block also gates a serial slave port. A registered inhibit flag follows reset, and a transfer grant is raised only when chip select falls while the port is not inhibited. When inhibit rises, any transfer in progress is aborted. A chip select that is already low when inhibit ends is not accepted. The host must raise chip select and lower it again to start a transfer.

Top module: `supply_reset_seq`

## Requirements
- R1: While rst_ni is low, reset_no is 0, bus_inhibit_o is 1 and bus_grant_o is 0.
- R2: reset_no rises at the clock edge that samples the HOLD_TICKS-th tick_i pulse counted while the synchronised supply flag is high. Before that edge it stays 0. Later ticks have no effect.
- R3: tick_i pulses that arrive while the synchronised supply flag is low are not counted.
- R4: vcc_ok_i passes through two flops. reset_no falls at the third clock edge after vcc_ok_i goes low.
- R5: A single low sample of the synchronised supply flag during the hold restarts the count from zero. After that, a full HOLD_TICKS ticks are needed again.
- R6: bus_inhibit_o equals the inverse of reset_no as it was one clock earlier.
- R7: bus_grant_o rises at the edge after a cycle in which cs_ni went from 1 to 0 while bus_inhibit_o was 0.
- R8: When bus_inhibit_o is 1 at an edge, bus_grant_o is 0 after that edge. A transfer in progress is aborted.
- R9: If cs_ni is held low across the end of inhibit, bus_grant_o stays 0 until cs_ni rises and falls again.
- R10: bus_grant_o returns to 0 at the edge after cs_ni is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse of the slow timebase |
| vcc_ok_i | input | 1 | Comparator flag, high when the supply is above trip (asynchronous) |
| cs_ni | input | 1 | Serial port chip select, active low, synchronous to clk_i |
| reset_no | output | 1 | Active-low system reset |
| bus_inhibit_o | output | 1 | High while serial access is refused |
| bus_grant_o | output | 1 | High while a serial transfer is accepted |

## Verification
The hardest case to reach is a supply glitch that arrives late in the hold. It has to land after most of the ticks, so that a design which merely pauses the count would release early. The directed stimulus first counts HOLD_TICKS-3 ticks, then drops vcc_ok_i for one cycle. It then proves that HOLD_TICKS-1 further ticks still leave reset low. A second hard case is chip select held low through the end of inhibit. The bench keeps cs_ni low through the whole release and only then toggles it. A randomised phase follows, with rare supply drops, sparse ticks and free chip-select toggling, compared each cycle against a bench model.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;
  localparam int unsigned DEF_HOLD_TICKS = 200;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/supply_sync.sv
module supply_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic tick_i,
  output logic release_o
);
  import supply_reset_pkg::*;
  localparam int unsigned CW = cnt_width(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  // any bad sample restarts the hold from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!good_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q && tick_i) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign release_o = rel_q;
endmodule

// File: rtl/bus_gate.sv
module bus_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  input  logic cs_ni,
  output logic grant_o
);
  logic cs_q;
  logic grant_q;
  logic cs_fall;

  assign cs_fall = cs_q & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      grant_q <= 1'b0;
    end else begin
      cs_q <= cs_ni;
      if (inhibit_i)    grant_q <= 1'b0;
      else if (cs_fall) grant_q <= 1'b1;
      else if (cs_ni)   grant_q <= 1'b0;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned HOLD_TICKS  = supply_reset_pkg::DEF_HOLD_TICKS,
  parameter int unsigned SYNC_STAGES = supply_reset_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vcc_ok_i,
  input  logic cs_ni,
  output logic reset_no,
  output logic bus_inhibit_o,
  output logic bus_grant_o
);
  logic vcc_s;
  logic rel;
  logic inh_q;

  supply_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vcc_ok_i),
    .q_o   (vcc_s)
  );

  hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .good_i   (vcc_s),
    .tick_i   (tick_i),
    .release_o(rel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inh_q <= 1'b1;
    else         inh_q <= ~rel;
  end

  bus_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inhibit_i(inh_q),
    .cs_ni    (cs_ni),
    .grant_o  (bus_grant_o)
  );

  assign reset_no      = rel;
  assign bus_inhibit_o = inh_q;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
  parameter int unsigned HOLD_TICKS = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic cs_ni,
  input logic vcc_s,
  input logic reset_no,
  input logic bus_inhibit_o,
  input logic bus_grant_o
);
  localparam int unsigned CW = supply_reset_pkg::cnt_width(HOLD_TICKS) + 1;
  logic [CW-1:0] seen_q;

  // independent tally of qualifying ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    seen_q <= '0;
    else if (!vcc_s)                seen_q <= '0;
    else if (tick_i && !reset_no)   seen_q <= seen_q + 1'b1;
  end

  p_release_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_no) |-> seen_q == CW'(HOLD_TICKS));
  p_release_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_no) |-> $past(tick_i) && $past(vcc_s));
  p_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_s |=> !reset_no);
  p_inhibit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_inhibit_o == !$past(reset_no));
  p_grant_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_grant_o) |-> !$past(cs_ni) && !$past(bus_inhibit_o));
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_inhibit_o |=> !bus_grant_o);
  p_cs_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !bus_grant_o);
endmodule

bind supply_reset_seq supply_reset_seq_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .cs_ni        (cs_ni),
  .vcc_s        (vcc_s),
  .reset_no     (reset_no),
  .bus_inhibit_o(bus_inhibit_o),
  .bus_grant_o  (bus_grant_o)
);

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;
  localparam int unsigned H = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic vcc = 1'b0;
  logic cs_n = 1'b1;
  logic rst_o, inh_o, gnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic m_s1, m_s2, m_rel, m_inh, m_csq, m_gnt;
  int   m_cnt;

  always #10 clk = ~clk;

  supply_reset_seq #(.HOLD_TICKS(H)) u_supply_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .vcc_ok_i(vcc), .cs_ni(cs_n),
    .reset_no(rst_o), .bus_inhibit_o(inh_o), .bus_grant_o(gnt_o)
  );

  function automatic void model_reset();
    m_s1 = 0; m_s2 = 0; m_rel = 0; m_inh = 1; m_csq = 1; m_gnt = 0; m_cnt = 0;
  endfunction

  function automatic void model_step();
    logic o_s1, o_s2, o_rel, o_inh, o_csq;
    o_s1 = m_s1; o_s2 = m_s2; o_rel = m_rel; o_inh = m_inh; o_csq = m_csq;
    m_s1 = vcc; m_s2 = o_s1;
    if (!o_s2) begin m_cnt = 0; m_rel = 0; end
    else if (!o_rel && tick) begin
      if (m_cnt == H - 1) m_rel = 1; else m_cnt++;
    end
    m_inh = !o_rel;
    m_csq = cs_n;
    if (o_inh) m_gnt = 0;
    else if (o_csq && !cs_n) m_gnt = 1;
    else if (cs_n) m_gnt = 0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    chk("R2 model reset_no", rst_o, m_rel);
    chk("R6 model inhibit", inh_o, m_inh);
    chk("R7 model grant", gnt_o, m_gnt);
  endtask

  task automatic pulse_tick();
    tick = 1; cyc(); tick = 0; cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) cyc();
    // R1 reset state
    chk("R1 reset_no", rst_o, 0);
    chk("R1 inhibit", inh_o, 1);
    chk("R1 grant", gnt_o, 0);
    @(negedge clk) rst_n = 1;
    cs_n = 0;  // held low across release for R9
    // R3 ticks while supply low ignored
    for (int i = 0; i < H + 4; i++) pulse_tick();
    chk("R3 no release while low", rst_o, 0);
    vcc = 1;
    repeat (3) cyc();
    for (int i = 0; i < H - 1; i++) pulse_tick();
    chk("R2 still held before last tick", rst_o, 0);
    tick = 1; cyc(); tick = 0;
    chk("R2 release on last tick", rst_o, 1);
    chk("R6 inhibit lags one cycle", inh_o, 1);
    cyc();
    chk("R6 inhibit cleared", inh_o, 0);
    repeat (4) cyc();
    chk("R9 held cs not granted", gnt_o, 0);
    cs_n = 1; cyc();
    cs_n = 0; cyc();
    chk("R7 grant after cs fall", gnt_o, 1);
    repeat (3) cyc();
    chk("R7 grant held", gnt_o, 1);
    cs_n = 1; cyc();
    chk("R10 grant drop on cs high", gnt_o, 0);
    cs_n = 0; cyc();
    chk("R7 second grant", gnt_o, 1);
    // R4 / R8 supply drop timing
    vcc = 0;
    cyc(); cyc();
    chk("R4 reset_no before third edge", rst_o, 1);
    cyc();
    chk("R4 reset_no at third edge", rst_o, 0);
    chk("R8 grant before inhibit", gnt_o, 1);
    cyc();
    chk("R6 inhibit after drop", inh_o, 1);
    cyc();
    chk("R8 grant aborted", gnt_o, 0);
    cs_n = 1;
    // R5 glitch late in hold
    vcc = 1; repeat (3) cyc();
    for (int i = 0; i < H - 3; i++) pulse_tick();
    vcc = 0; cyc(); vcc = 1; repeat (3) cyc();
    for (int i = 0; i < H - 1; i++) pulse_tick();
    chk("R5 glitch restarted count", rst_o, 0);
    pulse_tick();
    chk("R5 release after full hold", rst_o, 1);
    // randomised phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 100) < 2) vcc = ~vcc;
      else if (!vcc && ($urandom % 100) < 20) vcc = 1;
      tick = (($urandom % 3) == 0);
      if (($urandom % 5) == 0) cs_n = ~cs_n;
      cyc();
    end
    tick = 0;
    finish_run();
  end
endmodule